// File: doc/BRIEF.md
# Per-Block Flash Protection Controller

This block keeps a protection level for each erase block of a flash array and decides whether a program or erase operation may start on a given block. Each block is either open, locked, or held in lock-down. A lock-down holds the lock bit fixed while the write-protect pin is low. Lock-down ends only on a reset, never through a command. A supply-level indication shuts out every program and erase. It is looked at only in the cycle an operation starts, so a supply dip during an operation already running does not stop it.

Two sticky, one-time settings sit beside the block array. One permanently protects a chosen parameter block. The other freezes the user one-time-programmable field of the protection register. Neither is cleared by the hardware reset. Only the power-on initialisation clears them, and it stands in for the contents of the non-volatile array.

A command decoder drives lock, unlock and lock-down commands with a block index. An operation sequencer drives a start request and later a done pulse. Software reads back the level of any block through a combinational status port.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After power-on initialisation or a hardware reset, every block reports status 2'b01 (locked, no lock-down). The lock-error flag and the operation-active flag read 0.
- R2: A lock command (op 3'd0) sets a block's lock bit and an unlock command (op 3'd1) clears it. Only the addressed block changes, and the new level shows on the status port in the cycle after the command.
- R3: A lock-down command (op 3'd2) gives status 2'b11, where bit 1 is lock-down and bit 0 is lock. While wp_n is low, no command changes a block that has its lock-down bit set.
- R4: While wp_n is high, lock and unlock commands change the lock bit of a locked-down block and leave its lock-down bit set. An unlocked, locked-down block reads 2'b10 and can be programmed.
- R5: The lock-down bit of a block is cleared only by rst_n or por_n.
- R6: A start request gets resp_vld one cycle later. resp_ok is 1 only if vpp_ok was high and the target block was unlocked, within range and not permanently protected.
- R7: With vpp_ok low, every request is refused, including one to an unlocked block, and the lock-error flag is not raised for an unprotected target.
- R8: A granted operation keeps op_active high until op_done, whatever vpp_ok does meanwhile. Requests made while op_active is high get no response.
- R9: A request refused because its target is protected raises lock_err. The flag holds until a clear-error command (op 3'd5) or a reset, and a new refusal wins over a clear in the same cycle.
- R10: Command op 3'd3 permanently protects block PERM_BLK (default 0) and sets perm_set. Requests to that block are then refused even if it is unlocked. rst_n does not clear this; only por_n does.
- R11: Command op 3'd4 sets otp_locked. rst_n does not clear it; only por_n does.
- R12: Indexes at or above NUM_BLK (default 12) are ignored by commands, read as status 2'b01, and are refused with lock_err raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low; also clears the permanent settings |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 0 lock, 1 unlock, 2 lock-down, 3 permanent protect, 4 OTP lock, 5 clear error |
| cmd_blk | input | IDX_W | Target block of the command |
| wp_n | input | 1 | Write-protect pin; low freezes locked-down blocks |
| vpp_ok | input | 1 | Program supply above lockout level |
| req_vld | input | 1 | Program/erase start request |
| req_blk | input | IDX_W | Target block of the request |
| op_done | input | 1 | Running operation finished |
| stat_blk | input | IDX_W | Block whose status is read |
| stat_lvl | output | 2 | Status: bit 1 lock-down, bit 0 lock |
| perm_set | output | 1 | Parameter block permanently protected |
| otp_locked | output | 1 | User OTP field frozen |
| resp_vld | output | 1 | Response to a request |
| resp_ok | output | 1 | Request granted |
| op_active | output | 1 | Granted operation in progress |
| lock_err | output | 1 | Sticky protection-refusal flag |

## Verification
Requests are aimed at blocks in each level: locked, open, locked-down with the lock bit set or cleared, permanently protected, and out of range. Mixing these targets with vpp_ok high and low separates supply refusals, which leave lock_err alone, from protection refusals, which raise it. Commands are issued to a locked-down block with wp_n at each level, which shows that the pin freezes only the lock bit and that lock-down survives every command. A hardware reset near the end separates the volatile state, which returns to locked with no lock-down, from the permanent and OTP settings, which must remain. Dropping vpp_ok and issuing a second request during a running operation shows that the supply is looked at only when an operation starts and that the running operation blocks new requests.

// File: rtl/prot_pkg.sv
package prot_pkg;

   typedef enum logic [2:0] {
      OP_LOCK   = 3'd0,
      OP_UNLOCK = 3'd1,
      OP_LOCKDN = 3'd2,
      OP_PERM   = 3'd3,
      OP_OTPLK  = 3'd4,
      OP_CLRERR = 3'd5
   } prot_op_e;

   localparam logic [1:0] LVL_OPEN     = 2'b00;
   localparam logic [1:0] LVL_LOCKED   = 2'b01;
   localparam logic [1:0] LVL_LD_OPEN  = 2'b10;
   localparam logic [1:0] LVL_LD_LOCK  = 2'b11;

endpackage

// File: rtl/prot_blk_cell.sv
module prot_blk_cell
   import prot_pkg::*;
(
   input  logic     clk,
   input  logic     por_n,
   input  logic     rst_n,
   input  logic     sel,
   input  prot_op_e op,
   input  logic     wp_n,
   output logic     locked,
   output logic     lkdown
);

   logic frozen;
   assign frozen = lkdown & ~wp_n;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         locked <= 1'b1;
         lkdown <= 1'b0;
      end else if (!rst_n) begin
         locked <= 1'b1;
         lkdown <= 1'b0;
      end else if (sel && !frozen) begin
         case (op)
            OP_LOCK:   locked <= 1'b1;
            OP_UNLOCK: locked <= 1'b0;
            OP_LOCKDN: begin
               locked <= 1'b1;
               lkdown <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R3
   frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_n && sel && lkdown && !wp_n |=> (locked == $past(locked)) && lkdown);

   // R5
   ldn_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_n && lkdown |=> lkdown);

endmodule

// File: rtl/prot_sticky.sv
module prot_sticky (
   input  logic clk,
   input  logic por_n,
   input  logic set_perm,
   input  logic set_otp,
   output logic perm_q,
   output logic otp_q
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         perm_q <= 1'b0;
         otp_q  <= 1'b0;
      end else begin
         if (set_perm) perm_q <= 1'b1;
         if (set_otp)  otp_q  <= 1'b1;
      end
   end

   // R10
   perm_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      perm_q |=> perm_q);

   // R11
   otp_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      otp_q |=> otp_q);

endmodule

// File: rtl/prot_gate.sv
module prot_gate (
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic req_vld,
   input  logic tgt_prot,
   input  logic vpp_ok,
   input  logic op_done,
   input  logic clr_err,
   output logic resp_vld,
   output logic resp_ok,
   output logic op_active,
   output logic lock_err
);

   logic take;
   logic permit;

   assign take   = req_vld & ~op_active;
   assign permit = vpp_ok & ~tgt_prot;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         resp_vld  <= 1'b0;
         resp_ok   <= 1'b0;
         op_active <= 1'b0;
         lock_err  <= 1'b0;
      end else if (!rst_n) begin
         resp_vld  <= 1'b0;
         resp_ok   <= 1'b0;
         op_active <= 1'b0;
         lock_err  <= 1'b0;
      end else begin
         resp_vld <= take;
         resp_ok  <= take & permit;
         if (take && permit)  op_active <= 1'b1;
         else if (op_done)    op_active <= 1'b0;
         if (take && tgt_prot) lock_err <= 1'b1;
         else if (clr_err)     lock_err <= 1'b0;
      end
   end

   // R8
   op_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_n && op_active && !op_done |=> op_active);

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_n && op_active |=> !resp_vld);

   // R6
   refuse_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_n && take && (tgt_prot || !vpp_ok) |=> resp_vld && !resp_ok);

   // R9
   err_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_n && take && tgt_prot |=> lock_err);

endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
   import prot_pkg::*;
#(
   parameter int NUM_BLK  = 12,
   parameter int PERM_BLK = 0,
   parameter int IDX_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic             cmd_vld,
   input  logic [2:0]       cmd_op,
   input  logic [IDX_W-1:0] cmd_blk,
   input  logic             wp_n,
   input  logic             vpp_ok,
   input  logic             req_vld,
   input  logic [IDX_W-1:0] req_blk,
   input  logic             op_done,
   input  logic [IDX_W-1:0] stat_blk,
   output logic [1:0]       stat_lvl,
   output logic             perm_set,
   output logic             otp_locked,
   output logic             resp_vld,
   output logic             resp_ok,
   output logic             op_active,
   output logic             lock_err
);

   localparam int SPAN = 1 << IDX_W;

   if (NUM_BLK < 2) begin : g_bad_num
      $error("flash_prot_ctrl: NUM_BLK must be at least 2");
   end
   if (PERM_BLK < 0 || PERM_BLK >= NUM_BLK) begin : g_bad_perm
      $error("flash_prot_ctrl: PERM_BLK outside the block range");
   end
   if (SPAN < NUM_BLK) begin : g_bad_idx
      $error("flash_prot_ctrl: IDX_W too narrow for NUM_BLK");
   end

   prot_op_e         op;
   logic [SPAN-1:0]  lock_pad;
   logic [SPAN-1:0]  ldn_pad;
   logic             perm_q;
   logic             otp_q;
   logic             perm_hit;
   logic             tgt_prot;
   logic             clr_err;

   assign op = prot_op_e'(cmd_op);

   for (genvar i = 0; i < SPAN; i++) begin : g_blk
      if (i < NUM_BLK) begin : g_cell
         logic sel;
         assign sel = cmd_vld && (cmd_blk == IDX_W'(i));
         prot_blk_cell u_cell (
            .clk    (clk),
            .por_n  (por_n),
            .rst_n  (rst_n),
            .sel    (sel),
            .op     (op),
            .wp_n   (wp_n),
            .locked (lock_pad[i]),
            .lkdown (ldn_pad[i])
         );
      end else begin : g_pad
         assign lock_pad[i] = 1'b1;
         assign ldn_pad[i]  = 1'b0;
      end
   end

   prot_sticky u_sticky (
      .clk      (clk),
      .por_n    (por_n),
      .set_perm (cmd_vld && rst_n && (op == OP_PERM)),
      .set_otp  (cmd_vld && rst_n && (op == OP_OTPLK)),
      .perm_q   (perm_q),
      .otp_q    (otp_q)
   );

   assign perm_hit = perm_q && (req_blk == IDX_W'(PERM_BLK));
   assign tgt_prot = lock_pad[req_blk] | perm_hit;
   assign clr_err  = cmd_vld && (op == OP_CLRERR);

   prot_gate u_gate (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .req_vld   (req_vld),
      .tgt_prot  (tgt_prot),
      .vpp_ok    (vpp_ok),
      .op_done   (op_done),
      .clr_err   (clr_err),
      .resp_vld  (resp_vld),
      .resp_ok   (resp_ok),
      .op_active (op_active),
      .lock_err  (lock_err)
   );

   assign stat_lvl   = {ldn_pad[stat_blk], lock_pad[stat_blk]};
   assign perm_set   = perm_q;
   assign otp_locked = otp_q;

   // R10
   perm_refuse_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_n && req_vld && !op_active && perm_hit |=> !resp_ok);

   // R6
   grant_open_chk: assert property (@(posedge clk) disable iff (!por_n)
      resp_ok |-> $past(vpp_ok));

endmodule

// File: tb/sim_flash_prot_ctrl.sv
`timescale 1ns/100ps
module sim_flash_prot_ctrl;

   localparam int NB = 12;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          por_n, rst_n, cmd_vld, wp_n, vpp_ok, req_vld, op_done;
   logic [2:0]    cmd_op;
   logic [IW-1:0] cmd_blk, req_blk, stat_blk;
   logic [1:0]    stat_lvl;
   logic          perm_set, otp_locked, resp_vld, resp_ok, op_active, lock_err;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   bit    q_ok[$];
   string q_tag[$];

   always #2.5 clk = ~clk;

   flash_prot_ctrl u0 (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
      .cmd_blk(cmd_blk), .wp_n(wp_n), .vpp_ok(vpp_ok), .req_vld(req_vld),
      .req_blk(req_blk), .op_done(op_done), .stat_blk(stat_blk), .stat_lvl(stat_lvl),
      .perm_set(perm_set), .otp_locked(otp_locked), .resp_vld(resp_vld),
      .resp_ok(resp_ok), .op_active(op_active), .lock_err(lock_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops expected responses
   always @(negedge clk) begin
      if (resp_vld) begin
         if (q_ok.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL R8 unexpected response actual=1 expected=0");
         end else begin
            automatic bit    e = q_ok.pop_front();
            automatic string t = q_tag.pop_front();
            chk(t, int'(resp_ok), int'(e));
         end
      end
   end

   task automatic cmd(input logic [2:0] o, input int b);
      @(negedge clk);
      cmd_vld = 1'b1; cmd_op = o; cmd_blk = IW'(b);
      @(negedge clk);
      cmd_vld = 1'b0;
   endtask

   task automatic req(input int b, input bit exp_ok, input string tag);
      @(negedge clk);
      req_vld = 1'b1; req_blk = IW'(b);
      q_ok.push_back(exp_ok); q_tag.push_back(tag);
      @(negedge clk);
      req_vld = 1'b0;
      @(negedge clk);
   endtask

   task automatic done();
      @(negedge clk); op_done = 1'b1;
      @(negedge clk); op_done = 1'b0;
   endtask

   task automatic stat(input int b, input int exp, input string tag);
      @(negedge clk);
      stat_blk = IW'(b);
      #0.5;
      chk(tag, int'(stat_lvl), exp);
   endtask

   initial begin
      por_n = 0; rst_n = 0; cmd_vld = 0; cmd_op = 0; cmd_blk = 0;
      wp_n = 1; vpp_ok = 1; req_vld = 0; req_blk = 0; op_done = 0; stat_blk = 0;
      repeat (3) @(negedge clk);
      por_n = 1;
      @(negedge clk); rst_n = 1;
      // R1
      for (int i = 0; i < NB; i++) stat(i, 1, "R1 status after init");
      chk("R1 lock_err", int'(lock_err), 0);
      chk("R1 op_active", int'(op_active), 0);
      chk("R11 otp at init", int'(otp_locked), 0);
      // R6 / R9
      req(3, 1'b0, "R6 locked block refused");
      chk("R9 lock_err raised", int'(lock_err), 1);
      cmd(3'd5, 0);
      chk("R9 lock_err cleared", int'(lock_err), 0);
      // R2
      cmd(3'd1, 3);
      stat(3, 0, "R2 unlock block 3");
      stat(4, 1, "R2 neighbour untouched");
      // R8
      req(3, 1'b1, "R6 open block granted");
      chk("R8 op_active", int'(op_active), 1);
      vpp_ok = 0;
      repeat (3) @(negedge clk);
      chk("R8 active through supply drop", int'(op_active), 1);
      vpp_ok = 1;
      @(negedge clk); req_vld = 1; req_blk = 4;
      @(negedge clk); req_vld = 0;
      repeat (2) @(negedge clk);
      done();
      chk("R8 op ended by done", int'(op_active), 0);
      // R7
      vpp_ok = 0;
      req(3, 1'b0, "R7 supply low refused");
      chk("R7 no lock_err", int'(lock_err), 0);
      vpp_ok = 1;
      cmd(3'd0, 3);
      stat(3, 1, "R2 relock block 3");
      // R3 / R4
      cmd(3'd2, 6);
      stat(6, 3, "R3 lock-down");
      wp_n = 0;
      cmd(3'd1, 6);
      stat(6, 3, "R3 frozen unlock ignored");
      wp_n = 1;
      cmd(3'd1, 6);
      stat(6, 2, "R4 unlock with wp high");
      req(6, 1'b1, "R4 open locked-down granted");
      done();
      wp_n = 0;
      cmd(3'd0, 6);
      stat(6, 2, "R3 frozen lock ignored");
      wp_n = 1;
      cmd(3'd0, 6);
      stat(6, 3, "R4 relock with wp high");
      // R12
      cmd(3'd1, 13);
      stat(13, 1, "R12 out of range status");
      req(13, 1'b0, "R12 out of range refused");
      chk("R12 lock_err", int'(lock_err), 1);
      cmd(3'd5, 0);
      // R10
      cmd(3'd1, 0);
      stat(0, 0, "R10 block 0 open");
      req(0, 1'b1, "R10 granted before permanent");
      done();
      cmd(3'd3, 0);
      chk("R10 perm_set", int'(perm_set), 1);
      req(0, 1'b0, "R10 permanent refused");
      chk("R10 lock_err", int'(lock_err), 1);
      // R11
      cmd(3'd4, 0);
      chk("R11 otp locked", int'(otp_locked), 1);
      // R5 reset
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      stat(6, 1, "R5 lock-down cleared by reset");
      stat(3, 1, "R1 locked after reset");
      chk("R1 lock_err after reset", int'(lock_err), 0);
      chk("R10 perm survives reset", int'(perm_set), 1);
      chk("R11 otp survives reset", int'(otp_locked), 1);
      repeat (3) @(negedge clk);
      chk("R6 all responses seen", q_ok.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule